// File: doc/BRIEF.md
# Split Locked Access Bus Sequencer

This block takes one request for an atomic read-modify-write, or for an ordinary line fill, and turns it into the sequence of bus transactions that carries it. The request names a byte address, a byte count, the memory type of the page holding the first byte and of the page after it, whether the access is locked, and whether it is a read-for-ownership. The block checks whether the bytes run past the end of a page. If they do, it cuts the access into a lower half that ends at the page end and an upper half that starts at the next page base.

A locked request becomes a read phase followed by a write phase. The bus lock attribute is raised with the first read and held until the closing write is accepted, and no new request is taken in between. Ordinary fills become reads only. When such a fill is a read-for-ownership, a use-once rule marks it uncached, so the requester can consume the line once before another agent snoops it away, which avoids livelock. Locked loads are kept out of that rule, and so are writes, so a locked access keeps one consistent memory type per page across its reads and writes. Each transaction advances on a valid/ready handshake, and a one-cycle done pulse follows the last acceptance.

Top module: `lk_bus_sequencer`

## Requirements
- R1: A locked request that does not cross a page boundary issues exactly two transactions: kind 1 (locked read) and then kind 3 (locked write), both with the request's address and byte count. Kind encoding: 0 read, 1 locked read, 2 write, 3 locked write.
- R2: A request crosses a page boundary (default page 4096 bytes) when page offset plus byte count exceeds the page size. The lower half then uses the request address and the bytes up to the page end, and the upper half uses the next page base address and the remaining bytes. Ending exactly on the page end is not a crossing.
- R3: A locked request that crosses a page boundary issues four transactions in this order: locked read of the lower half (kind 1), read of the upper half (kind 0), write of the upper half (kind 2), locked write of the lower half (kind 3).
- R4: Transactions of a locked request carry the page memory type of their half (lower page for the lower half, upper page for the upper half), and the ownership-read flag never changes them. With both pages WB (6), all four split transactions carry 6.
- R5: A read of a request that is not locked carries UC (0) when the ownership-read flag is set, whatever the page type. Without the flag it carries the page type of its half.
- R6: A request that is not locked issues only kind-0 reads: one when it fits in a page, two (lower then upper) when it crosses.
- R7: bus_lock is high from the first transaction of a locked request until the cycle its final write is accepted. It is low in reset, in idle, and during any request that is not locked.
- R8: While bus_valid is high and bus_ready is low, bus_valid and every transaction field stay unchanged. A sequence advances only when a transaction is accepted.
- R9: done is high for exactly one cycle, the cycle after the last transaction of a request is accepted, and is otherwise low.
- R10: req_ready is high in reset and idle, and low from the cycle after a request is accepted until done. The first transaction appears the cycle after acceptance, and a request held during a sequence waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_len | input | LEN_W | Byte count (1 or more) |
| req_mt_lo | input | 3 | Memory type of the page holding the first byte |
| req_mt_hi | input | 3 | Memory type of the following page |
| req_locked | input | 1 | Atomic read-modify-write request |
| req_rfo | input | 1 | Fill is a read-for-ownership |
| bus_valid | output | 1 | Transaction present on the bus port |
| bus_ready | input | 1 | Bus accepts the transaction |
| bus_kind | output | 2 | Transaction kind (0 rd, 1 locked rd, 2 wr, 3 locked wr) |
| bus_lock | output | 1 | Bus lock attribute |
| bus_mt | output | 3 | Memory type of the transaction |
| bus_addr | output | ADDR_W | Address of the transaction |
| bus_len | output | LEN_W | Byte count of the transaction |
| done | output | 1 | One-cycle completion pulse |

## Verification
The central case is a locked split access with an ownership-read flag and WB on both pages. A design that applies use-once to the locked load would show UC on the two reads and WB on the writes, and the model catches the mismatch on the first read. Accesses that end exactly on the page end, or that start on the last byte of a page, probe the split test and the half lengths. An off-by-one there would emit a spurious zero-length upper half or put the wrong address on the second transaction. Stretches of deasserted bus_ready check that fields hold steady, that the lock stays up between the read and write phases, and that a request held during a sequence is not taken early. A design that let the lock drop, or that accepted the new request mid-sequence, would diverge from the model on bus_lock or req_ready.

// File: rtl/lk_pkg.sv
// Package: shared encodings for the locked access sequencer.
// Assumes: 3-bit memory type field, 2-bit transaction kind.
package lk_pkg;
    typedef enum logic [1:0] {
        KIND_RD    = 2'd0,
        KIND_RD_LK = 2'd1,
        KIND_WR    = 2'd2,
        KIND_WR_LK = 2'd3
    } kind_e;

    localparam logic [2:0] MT_UC = 3'd0;
    localparam logic [2:0] MT_WB = 3'd6;
endpackage

// File: rtl/lk_page_split.sv
// Module: lk_page_split
// Decides whether an access crosses a page boundary and sizes its halves.
// Assumes: LEN_W <= PAGE_W and len >= 1, so a split leaves both halves non-empty.
module lk_page_split #(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12,
    parameter int LEN_W  = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              split_o,
    output logic [LEN_W-1:0]  lo_len_o,
    output logic [ADDR_W-1:0] hi_addr_o,
    output logic [LEN_W-1:0]  hi_len_o
);
    localparam int PN_W = ADDR_W - PAGE_W;

    logic [PAGE_W:0] page_sz;
    logic [PAGE_W:0] off_ext;
    logic [PAGE_W:0] len_ext;
    logic [PAGE_W:0] end_ext;
    logic [PAGE_W:0] room;
    logic [PN_W-1:0] page_nxt;

    // Offset arithmetic one bit wider than the page so the end cannot wrap.
    always_comb begin
        page_sz  = {1'b1, {PAGE_W{1'b0}}};
        off_ext  = {1'b0, addr_i[PAGE_W-1:0]};
        len_ext  = {{(PAGE_W+1-LEN_W){1'b0}}, len_i};
        end_ext  = off_ext + len_ext;
        room     = page_sz - off_ext;
        split_o  = end_ext > page_sz;
        lo_len_o = split_o ? room[LEN_W-1:0] : len_i;
        hi_len_o = len_i - lo_len_o;
        page_nxt = addr_i[ADDR_W-1:PAGE_W] + {{(PN_W-1){1'b0}}, 1'b1};
        hi_addr_o = {page_nxt, {PAGE_W{1'b0}}};
    end
endmodule

// File: rtl/lk_mt_policy.sv
// Module: lk_mt_policy
// Picks the memory type of reads and writes for each half of an access.
// Assumes: use-once forcing applies only to unlocked ownership reads, never to writes.
module lk_mt_policy
    import lk_pkg::*;
(
    input  logic       locked_i,
    input  logic       rfo_i,
    input  logic [2:0] mt_lo_i,
    input  logic [2:0] mt_hi_i,
    output logic [2:0] rd_mt_lo_o,
    output logic [2:0] rd_mt_hi_o,
    output logic [2:0] wr_mt_lo_o,
    output logic [2:0] wr_mt_hi_o
);
    logic use_once;

    // Reads may be forced uncached; writes always keep the page type.
    always_comb begin
        use_once   = rfo_i && !locked_i;
        rd_mt_lo_o = use_once ? MT_UC : mt_lo_i;
        rd_mt_hi_o = use_once ? MT_UC : mt_hi_i;
        wr_mt_lo_o = mt_lo_i;
        wr_mt_hi_o = mt_hi_i;
    end
endmodule

// File: rtl/lk_step_decode.sv
// Module: lk_step_decode
// Maps a step index to the transaction kind, the half it targets and the last-step flag.
// Assumes: step stays below the step count of the current request shape.
module lk_step_decode
    import lk_pkg::*;
(
    input  logic [1:0] step_i,
    input  logic       locked_i,
    input  logic       split_i,
    output kind_e      kind_o,
    output logic       upper_o,
    output logic       last_o
);
    // Fixed orderings per request shape: locked split, locked whole, fill split, fill whole.
    always_comb begin
        kind_o  = KIND_RD;
        upper_o = 1'b0;
        last_o  = 1'b0;
        unique case ({locked_i, split_i})
            2'b11: begin
                unique case (step_i)
                    2'd0: kind_o = KIND_RD_LK;
                    2'd1: begin kind_o = KIND_RD; upper_o = 1'b1; end
                    2'd2: begin kind_o = KIND_WR; upper_o = 1'b1; end
                    default: begin kind_o = KIND_WR_LK; last_o = 1'b1; end
                endcase
            end
            2'b10: begin
                kind_o = (step_i == 2'd0) ? KIND_RD_LK : KIND_WR_LK;
                last_o = (step_i != 2'd0);
            end
            2'b01: begin
                upper_o = (step_i != 2'd0);
                last_o  = (step_i != 2'd0);
            end
            default: last_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/lk_bus_sequencer.sv
// Module: lk_bus_sequencer (top)
// Accepts one request at a time and issues its bus transactions with kind, lock and memory type.
// Assumes: req_len >= 1 and no larger than a page; bus_ready may stall any transaction.
module lk_bus_sequencer
    import lk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PAGE_W = 12,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [2:0]        req_mt_lo,
    input  logic [2:0]        req_mt_hi,
    input  logic              req_locked,
    input  logic              req_rfo,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [1:0]        bus_kind,
    output logic              bus_lock,
    output logic [2:0]        bus_mt,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [LEN_W-1:0]  bus_len,
    output logic              done
);
    logic              split_c;
    logic [LEN_W-1:0]  lo_len_c, hi_len_c;
    logic [ADDR_W-1:0] hi_addr_c;
    logic [2:0]        rd_lo_c, rd_hi_c, wr_lo_c, wr_hi_c;

    logic              busy_q, lock_q, done_q, locked_q, split_q;
    logic [1:0]        step_q;
    logic [ADDR_W-1:0] addr_lo_q, addr_hi_q;
    logic [LEN_W-1:0]  len_lo_q, len_hi_q;
    logic [2:0]        rd_lo_q, rd_hi_q, wr_lo_q, wr_hi_q;

    kind_e             cur_kind;
    logic              cur_upper, cur_last;
    logic              req_acc, bus_acc;

    lk_page_split #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_split (
        .addr_i   (req_addr),
        .len_i    (req_len),
        .split_o  (split_c),
        .lo_len_o (lo_len_c),
        .hi_addr_o(hi_addr_c),
        .hi_len_o (hi_len_c)
    );

    lk_mt_policy u_policy (
        .locked_i  (req_locked),
        .rfo_i     (req_rfo),
        .mt_lo_i   (req_mt_lo),
        .mt_hi_i   (req_mt_hi),
        .rd_mt_lo_o(rd_lo_c),
        .rd_mt_hi_o(rd_hi_c),
        .wr_mt_lo_o(wr_lo_c),
        .wr_mt_hi_o(wr_hi_c)
    );

    lk_step_decode u_decode (
        .step_i  (step_q),
        .locked_i(locked_q),
        .split_i (split_q),
        .kind_o  (cur_kind),
        .upper_o (cur_upper),
        .last_o  (cur_last)
    );

    assign req_acc = req_valid && req_ready;
    assign bus_acc = bus_valid && bus_ready;

    // Drive the bus port from the captured request and the decoded step.
    always_comb begin
        req_ready = !busy_q;
        bus_valid = busy_q;
        bus_kind  = cur_kind;
        bus_lock  = lock_q;
        bus_addr  = cur_upper ? addr_hi_q : addr_lo_q;
        bus_len   = cur_upper ? len_hi_q : len_lo_q;
        if (cur_kind[1]) bus_mt = cur_upper ? wr_hi_q : wr_lo_q;
        else             bus_mt = cur_upper ? rd_hi_q : rd_lo_q;
        done      = done_q;
    end

    // Sequence state: capture on request accept, step on bus accept, pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            lock_q    <= 1'b0;
            done_q    <= 1'b0;
            locked_q  <= 1'b0;
            split_q   <= 1'b0;
            step_q    <= 2'd0;
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            len_lo_q  <= '0;
            len_hi_q  <= '0;
            rd_lo_q   <= MT_UC;
            rd_hi_q   <= MT_UC;
            wr_lo_q   <= MT_UC;
            wr_hi_q   <= MT_UC;
        end else begin
            done_q <= 1'b0;
            if (req_acc) begin
                busy_q    <= 1'b1;
                lock_q    <= req_locked;
                locked_q  <= req_locked;
                split_q   <= split_c;
                step_q    <= 2'd0;
                addr_lo_q <= req_addr;
                addr_hi_q <= hi_addr_c;
                len_lo_q  <= lo_len_c;
                len_hi_q  <= hi_len_c;
                rd_lo_q   <= rd_lo_c;
                rd_hi_q   <= rd_hi_c;
                wr_lo_q   <= wr_lo_c;
                wr_hi_q   <= wr_hi_c;
            end else if (bus_acc) begin
                if (cur_last) begin
                    busy_q <= 1'b0;
                    lock_q <= 1'b0;
                    done_q <= 1'b1;
                    step_q <= 2'd0;
                end else begin
                    step_q <= step_q + 2'd1;
                end
            end
        end
    end

    // R8: a stalled transaction holds still.
    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_kind) && $stable(bus_mt)
                                       && $stable(bus_addr) && $stable(bus_len) && $stable(bus_lock)));

    // R9: done follows an acceptance and lasts one cycle.
    assert_done_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_valid && bus_ready));
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: every locked-phase kind is issued under the lock.
    assert_lock_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_kind != 2'd0) |-> bus_lock);

    // R6: without the lock only plain reads appear.
    assert_unlocked_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_lock) |-> (bus_kind == 2'd0));

    // R10: an accepted request starts its sequence next cycle and closes the request port.
    assert_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_valid && !req_ready));
endmodule

// File: tb/tb_lk_bus_sequencer.sv
module tb_lk_bus_sequencer;
    localparam int ADDR_W = 32;
    localparam int PAGE_W = 12;
    localparam int LEN_W  = 4;
    localparam int PAGE   = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [2:0]        req_mt_lo = '0;
    logic [2:0]        req_mt_hi = '0;
    logic              req_locked = 1'b0;
    logic              req_rfo = 1'b0;
    logic              bus_valid;
    logic              bus_ready = 1'b1;
    logic [1:0]        bus_kind;
    logic              bus_lock;
    logic [2:0]        bus_mt;
    logic [ADDR_W-1:0] bus_addr;
    logic [LEN_W-1:0]  bus_len;
    logic              done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rmode  = 0;

    lk_bus_sequencer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .req_mt_lo(req_mt_lo), .req_mt_hi(req_mt_hi), .req_locked(req_locked), .req_rfo(req_rfo),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_kind(bus_kind), .bus_lock(bus_lock),
        .bus_mt(bus_mt), .bus_addr(bus_addr), .bus_len(bus_len), .done(done)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    kind;
        int    mt;
        longint addr;
        int    len;
        string ktag;
        string mtag;
    } txn_t;

    txn_t   q[$];
    bit     busy_m = 0, done_due = 0, lock_exp = 0, stall = 0;
    int     s_kind, s_mt, s_len;
    longint s_addr;
    bit     s_lock;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp,
                       input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: builds the expected transaction list from the requirements.
    function automatic void build(longint a, int n, int mlo, int mhi, bit lk, bit rfo);
        int  off = int'(a % PAGE);
        bit  sp  = (off + n) > PAGE;
        int  llo = sp ? PAGE - off : n;
        longint ahi = (a / PAGE + 1) * PAGE;
        int  rlo = (!lk && rfo) ? 0 : mlo;
        int  rhi = (!lk && rfo) ? 0 : mhi;
        string kt = lk ? (sp ? "R3" : "R1") : "R6";
        string mtg = lk ? "R4" : "R5";
        txn_t t;
        t.ktag = kt; t.mtag = mtg;
        if (lk) begin
            t.kind = 1; t.mt = mlo; t.addr = a; t.len = llo; q.push_back(t);
            if (sp) begin
                t.kind = 0; t.mt = mhi; t.addr = ahi; t.len = n - llo; q.push_back(t);
                t.kind = 2; q.push_back(t);
            end
            t.kind = 3; t.mt = mlo; t.addr = a; t.len = llo; q.push_back(t);
        end else begin
            t.kind = 0; t.mt = rlo; t.addr = a; t.len = llo; q.push_back(t);
            if (sp) begin
                t.mt = rhi; t.addr = ahi; t.len = n - llo; q.push_back(t);
            end
        end
    endfunction

    // Ready pattern driver.
    always @(negedge clk) begin
        cyc++;
        case (rmode)
            0: bus_ready = 1'b1;
            1: bus_ready = (cyc % 3) != 0;
            default: bus_ready = (cyc % 5) == 4;
        endcase
    end

    // Per-cycle comparison against the model, sampled mid low phase.
    always begin
        @(negedge clk);
        #2;
        if (!rst_n) begin
            q.delete(); busy_m = 0; done_due = 0; lock_exp = 0; stall = 0;
        end else begin
            chk(req_ready == !busy_m, "R10", req_ready, !busy_m, "req_ready");
            chk(done == done_due, "R9", done, done_due, "done");
            done_due = 0;
            chk(bus_lock == lock_exp, "R7", bus_lock, lock_exp, "bus_lock");
            chk(bus_valid == (q.size() != 0), "R8", bus_valid, q.size() != 0, "bus_valid");
            if (stall && bus_valid) begin
                chk(bus_kind == s_kind && bus_mt == s_mt && bus_addr == s_addr
                    && bus_len == s_len && bus_lock == s_lock,
                    "R8", bus_addr, s_addr, "stalled fields changed");
            end
            if (bus_valid && q.size() != 0) begin
                chk(bus_kind == q[0].kind, q[0].ktag, bus_kind, q[0].kind, "kind");
                chk(bus_mt == q[0].mt, q[0].mtag, bus_mt, q[0].mt, "memory type");
                chk(bus_addr == q[0].addr, "R2", bus_addr, q[0].addr, "address");
                chk(bus_len == q[0].len, "R2", bus_len, q[0].len, "length");
            end
            stall = bus_valid && !bus_ready;
            s_kind = bus_kind; s_mt = bus_mt; s_addr = bus_addr; s_len = bus_len; s_lock = bus_lock;
            if (bus_valid && bus_ready && q.size() != 0) begin
                void'(q.pop_front());
                if (q.size() == 0) begin
                    busy_m = 0; done_due = 1; lock_exp = 0;
                end
            end
            if (req_valid && req_ready) begin
                build(req_addr, req_len, req_mt_lo, req_mt_hi, req_locked, req_rfo);
                busy_m = 1; lock_exp = req_locked;
            end
        end
    end

    task automatic send(input longint a, input int n, input int mlo, input int mhi,
                        input bit lk, input bit rfo);
        @(negedge clk);
        req_addr = a[ADDR_W-1:0]; req_len = n[LEN_W-1:0];
        req_mt_lo = mlo[2:0]; req_mt_hi = mhi[2:0];
        req_locked = lk; req_rfo = rfo; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy_m || done_due || req_valid);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        fails++; checks++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk(req_ready == 1'b1, "R10", req_ready, 1, "reset req_ready");
        chk(bus_valid == 1'b0, "R8", bus_valid, 0, "reset bus_valid");
        chk(done == 1'b0, "R9", done, 0, "reset done");
        chk(bus_lock == 1'b0, "R7", bus_lock, 0, "reset bus_lock");
        @(negedge clk); rst_n = 1'b1;

        // R1: locked access inside one page
        rmode = 0;
        send(32'h0000_1010, 8, 6, 6, 1, 0); wait_idle();
        // R3, R4: split locked, both pages WB, ownership flag set: all WB
        send(32'h0000_2FFC, 8, 6, 6, 1, 1); wait_idle();
        // R4: split locked with mixed page types
        send(32'h0000_3FFA, 8, 0, 6, 1, 0); wait_idle();
        // R5: unlocked ownership fill, forced uncached
        send(32'h0000_4040, 8, 6, 6, 0, 1); wait_idle();
        // R5, R6: unlocked ownership fill across a page
        send(32'h0000_4FFE, 4, 6, 6, 0, 1); wait_idle();
        // R5, R6: plain fill across a page keeps page types
        send(32'h0000_5FF9, 8, 6, 4, 0, 0); wait_idle();
        // R2: ends exactly at page end, no split
        send(32'h0000_6FF8, 8, 6, 6, 1, 0); wait_idle();
        // R2: starts on last byte of a page
        send(32'h0000_7FFF, 2, 6, 6, 1, 0); wait_idle();
        // R8, R7: stalls inside a locked split sequence
        rmode = 1;
        send(32'h0000_8FFD, 6, 6, 6, 1, 1); wait_idle();
        rmode = 2;
        send(32'h0000_9FFB, 8, 4, 6, 1, 0); wait_idle();
        // R10: second request held while the first is in progress
        send(32'h0000_AFFC, 8, 6, 6, 1, 0);
        send(32'h0000_B100, 4, 6, 6, 0, 1);
        wait_idle();
        rmode = 0;
        // back-to-back with full ready
        send(32'h0000_C000, 1, 6, 6, 1, 0);
        send(32'h0000_CFFF, 15, 6, 0, 0, 0);
        wait_idle();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule